// File: doc/BRIEF.md
# Two-Level Page Table Walker with Protection

This block translates a 32-bit virtual address into a physical address by reading two page-table entries from memory, one after the other, and then checking the access rights of the final entry. A request carries the virtual address, a write flag and a user-mode flag. The walk starts from a root table base supplied by the processor. The walker takes the root base when it accepts the request.

The virtual address has three fields. Bits 31:22 index the first-level table, bits 21:12 index the second-level table, and bits 11:0 are the page offset. The first-level entry gives the frame of a second-level table. The second-level entry gives the physical frame of the page. Each entry is checked as it returns. A walk that fails at any step stops at once and reports one exception code. A walk that succeeds reports the physical address. The memory port is a single read channel: the walker holds the request and the address until a one-cycle read-valid returns the entry.

Top module: `ptw_walker`

## Requirements
- R1: After a request is accepted, the first memory read is at root base + (va[31:22] × 4), where the root base is the value sampled on the accept cycle.
- R2: After a usable first-level entry, the second read is at ({entry[31:12], 12'h000}) + (va[21:12] × 4).
- R3: A walk that succeeds reports resp_fault_o=0, resp_cause_o=0 and resp_paddr_o = {leaf entry[31:12], va[11:0]}.
- R4: An entry with bit 0 (valid) clear, at either level, ends the walk with cause 1 (invalid). No further read is issued.
- R5: A valid entry with bit 1 (resident) clear, at either level, ends the walk with cause 2 (page fault, not resident). No further read is issued.
- R6: In user mode, a leaf entry with bit 3 (user) clear gives cause 4 (user violation). In kernel mode bit 3 is ignored.
- R7: A write to a leaf entry with bit 2 (writable) clear gives cause 3 (write violation). Reads ignore bit 2. Permission bits of the first-level entry are ignored.
- R8: When several leaf conditions hold at once, the cause reported follows this priority: invalid first, then not resident, then user violation, then write violation.
- R9: A request is accepted only while busy_o is low. busy_o stays high from the cycle after acceptance until the response cycle ends. A request raised while busy is ignored and starts no read.
- R10: Each accepted request gives exactly one resp_valid_o pulse, one cycle long, carrying either an address or an exception.
- R11: During reset and after it, busy_o, mem_req_o and resp_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| root_base_i | input | 32 | Base address of the first-level table |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| busy_o | output | 1 | Walk in progress; new requests are not taken |
| mem_req_o | output | 1 | Entry read request, held until read-valid |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_rvalid_i | input | 1 | Entry data valid (one cycle) |
| mem_rdata_i | input | 32 | Entry data |
| resp_valid_o | output | 1 | Result valid (one cycle) |
| resp_paddr_o | output | 32 | Physical address; 0 when the result is a fault |
| resp_fault_o | output | 1 | Result is an exception |
| resp_cause_o | output | 3 | 0 none, 1 invalid, 2 not resident, 3 write violation, 4 user violation |

## Verification
A fault in the walk state shows on the memory port within one read. The symptoms are a read at the wrong entry address, a second read after a fault entry, or a missing second read. A bad decode of an entry shows in the cause or address of the single response, a few cycles after the last read returns. A broken busy or accept path shows as a missing response, a duplicate response, or reads issued for a request that arrived while busy. All of these appear in the same walk that triggers them.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_INVALID = 3'd1,
    CAUSE_NOT_RES = 3'd2,
    CAUSE_WRITE   = 3'd3,
    CAUSE_USER    = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_RESP
  } state_e;

  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned BIT_VLD = 0;
  localparam int unsigned BIT_RES = 1;
  localparam int unsigned BIT_WR  = 2;
  localparam int unsigned BIT_USR = 3;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned VA_W = 2 * IDX_W + OFF_W
) (
  input  logic [VA_W-1:0]  va_i,
  output logic [IDX_W-1:0] idx_hi_o,
  output logic [IDX_W-1:0] idx_lo_o,
  output logic [OFF_W-1:0] off_o
);
  assign idx_hi_o = va_i[OFF_W+IDX_W +: IDX_W];
  assign idx_lo_o = va_i[OFF_W +: IDX_W];
  assign off_o    = va_i[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PA_W  = 32
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  addr_o
);
  localparam int unsigned PAD_W = PA_W - IDX_W - 2;
  // entries are 4 bytes
  assign addr_o = base_i + {{PAD_W{1'b0}}, idx_i, 2'b00};
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter bit LEAF = 1'b1
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              write_i,
  input  logic              user_i,
  output logic              fault_o,
  output cause_e            cause_o
);
  logic perm_user_bad, perm_write_bad;

  generate
    if (LEAF) begin : g_leaf
      assign perm_user_bad  = user_i && !flags_i[BIT_USR];
      assign perm_write_bad = write_i && !flags_i[BIT_WR];
    end else begin : g_dir
      logic unused_dir;
      assign unused_dir     = ^{write_i, user_i, flags_i[BIT_USR], flags_i[BIT_WR]};
      assign perm_user_bad  = 1'b0;
      assign perm_write_bad = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!flags_i[BIT_VLD])      cause_o = CAUSE_INVALID;
    else if (!flags_i[BIT_RES]) cause_o = CAUSE_NOT_RES;
    else if (perm_user_bad)     cause_o = CAUSE_USER;
    else if (perm_write_bad)    cause_o = CAUSE_WRITE;
    else                        cause_o = CAUSE_NONE;
  end
  assign fault_o = (cause_o != CAUSE_NONE);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 32,
  localparam int unsigned VA_W = 2 * IDX_W + OFF_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PA_W-1:0] root_base_i,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic            req_write_i,
  input  logic            req_user_i,
  output logic            busy_o,
  output logic            mem_req_o,
  output logic [PA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [PA_W-1:0] mem_rdata_i,
  output logic            resp_valid_o,
  output logic [PA_W-1:0] resp_paddr_o,
  output logic            resp_fault_o,
  output logic [2:0]      resp_cause_o
);
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  state_e            state_q;
  logic [VA_W-1:0]   va_q;
  logic              wr_q, usr_q;
  logic [PA_W-1:0]   base_q;
  logic [PA_W-1:0]   paddr_q;
  logic              fault_q;
  cause_e            cause_q;

  logic [IDX_W-1:0]  idx_hi, idx_lo, idx_cur;
  logic [OFF_W-1:0]  off;
  logic [FRAME_W-1:0] pte_frame;
  logic [FLAG_W-1:0] pte_flags;
  logic              dir_fault, leaf_fault;
  cause_e            dir_cause, leaf_cause;
  logic              unused_pte_bits;

  ptw_va_split #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .va_i     (va_q),
    .idx_hi_o (idx_hi),
    .idx_lo_o (idx_lo),
    .off_o    (off)
  );

  assign idx_cur = (state_q == ST_L2) ? idx_lo : idx_hi;

  ptw_entry_addr #(.IDX_W(IDX_W), .PA_W(PA_W)) u_eaddr (
    .base_i (base_q),
    .idx_i  (idx_cur),
    .addr_o (mem_addr_o)
  );

  assign pte_frame       = mem_rdata_i[PA_W-1:OFF_W];
  assign pte_flags       = mem_rdata_i[FLAG_W-1:0];
  assign unused_pte_bits = ^mem_rdata_i[OFF_W-1:FLAG_W];

  ptw_pte_eval #(.LEAF(1'b0)) u_dir_eval (
    .flags_i (pte_flags),
    .write_i (wr_q),
    .user_i  (usr_q),
    .fault_o (dir_fault),
    .cause_o (dir_cause)
  );

  ptw_pte_eval #(.LEAF(1'b1)) u_leaf_eval (
    .flags_i (pte_flags),
    .write_i (wr_q),
    .user_i  (usr_q),
    .fault_o (leaf_fault),
    .cause_o (leaf_cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      base_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          wr_q    <= req_write_i;
          usr_q   <= req_user_i;
          base_q  <= root_base_i;
          state_q <= ST_L1;
        end
        ST_L1: if (mem_rvalid_i) begin
          if (dir_fault) begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            cause_q <= dir_cause;
            state_q <= ST_RESP;
          end else begin
            base_q  <= {pte_frame, {OFF_W{1'b0}}};
            state_q <= ST_L2;
          end
        end
        ST_L2: if (mem_rvalid_i) begin
          paddr_q <= leaf_fault ? '0 : {pte_frame, off};
          fault_q <= leaf_fault;
          cause_q <= leaf_cause;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign mem_req_o    = (state_q == ST_L1) || (state_q == ST_L2);
  assign resp_valid_o = (state_q == ST_RESP);
  assign resp_paddr_o = paddr_q;
  assign resp_fault_o = fault_q;
  assign resp_cause_o = cause_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned VA_W  = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            resp_valid_o,
  input logic [PA_W-1:0] resp_paddr_o,
  input logic            resp_fault_o,
  input logic [2:0]      resp_cause_o
);
  logic [OFF_W-1:0] off_cap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_cap_q <= '0;
    else if (req_valid_i && !busy_o) off_cap_q <= req_vaddr_i[OFF_W-1:0];
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i)
    !rst_ni |=> !busy_o && !mem_req_o && !resp_valid_o); // R11
  AST_READ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R9
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o && mem_req_o); // R9
  AST_READ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)); // R1
  AST_ENTRY_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o && !busy_o); // R10
  AST_CAUSE_MATCHES_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_fault_o == (resp_cause_o != 3'd0)) && resp_cause_o <= 3'd4); // R8
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_fault_o |-> resp_paddr_o[OFF_W-1:0] == off_cap_q); // R3
endmodule

bind ptw_walker ptw_walker_chk #(.OFF_W(OFF_W), .PA_W(PA_W), .VA_W(VA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_vaddr_i  (req_vaddr_i),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .resp_valid_o (resp_valid_o),
  .resp_paddr_o (resp_paddr_o),
  .resp_fault_o (resp_fault_o),
  .resp_cause_o (resp_cause_o)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  localparam int LAT = 2;
  localparam logic [31:0] ROOT = 32'h0000_4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] root_base_i = ROOT;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_user_i = 1'b0;
  logic        busy_o, mem_req_o, mem_rvalid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata_i = '0;
  logic        resp_valid_o, resp_fault_o;
  logic [31:0] resp_paddr_o;
  logic [2:0]  resp_cause_o;

  int errors = 0, checks = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] fetch_addr [4];
  int fetch_n = 0, lat_cnt = 0;

  always #2.5 clk_i = ~clk_i;

  ptw_walker u_dut (.*);

  always @(negedge clk_i) begin
    if (mem_rvalid_i) mem_rvalid_i = 1'b0;
    else if (mem_req_o) begin
      if (lat_cnt == LAT) begin
        mem_rdata_i  = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
        mem_rvalid_i = 1'b1;
        if (fetch_n < 4) fetch_addr[fetch_n] = mem_addr_o;
        fetch_n++;
        lat_cnt = 0;
      end else lat_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] l1_addr(input logic [31:0] va);
    return ROOT + {20'h0, va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] l2_addr(input logic [19:0] tf, input logic [31:0] va);
    return {tf, 12'h0} + {20'h0, va[21:12], 2'b00};
  endfunction

  task automatic map(input logic [31:0] va, input logic [19:0] tf, input logic [3:0] dfl,
                     input logic [19:0] pf, input logic [3:0] lfl);
    mem[l1_addr(va)] = {tf, 8'h0, dfl};
    mem[l2_addr(tf, va)] = {pf, 8'h0, lfl};
  endtask

  logic [31:0] r_pa; logic r_f; logic [2:0] r_c; int r_n;

  task automatic walk(input logic [31:0] va, input bit wr, input bit usr, input bit intrude);
    fetch_n = 0; r_n = 0;
    @(negedge clk_i);
    req_vaddr_i = va; req_write_i = wr; req_user_i = usr; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(busy_o, "R9 busy after accept", {31'h0, busy_o}, 32'h1);
    for (int i = 0; i < 40; i++) begin
      if (intrude && i == 1) begin
        req_valid_i = 1'b1; req_vaddr_i = 32'h0C00_0000; req_write_i = ~wr;
      end else req_valid_i = 1'b0;
      @(negedge clk_i);
      if (resp_valid_o) begin
        r_n++; r_pa = resp_paddr_o; r_f = resp_fault_o; r_c = resp_cause_o;
      end
    end
    req_valid_i = 1'b0;
    chk(r_n == 1, "R10 one response", r_n, 1);
    chk(!busy_o, "R9 idle after walk", {31'h0, busy_o}, 32'h0);
  endtask

  task automatic expect_ok(input string req, input logic [31:0] pa);
    chk(!r_f && r_c == 3'd0, req, {28'h0, r_f, r_c}, 32'h0);
    chk(r_pa == pa, req, r_pa, pa);
    chk(fetch_n == 2, req, fetch_n, 2);
  endtask

  task automatic expect_fault(input string req, input logic [2:0] c, input int nf);
    chk(r_f && r_c == c, req, {28'h0, r_f, r_c}, {28'h0, 1'b1, c});
    chk(fetch_n == nf, req, fetch_n, nf);
  endtask

  task automatic t_reset;
    #1;
    chk(!busy_o && !mem_req_o && !resp_valid_o, "R11 reset outputs",
        {29'h0, busy_o, mem_req_o, resp_valid_o}, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !mem_req_o && !resp_valid_o, "R11 after reset",
        {29'h0, busy_o, mem_req_o, resp_valid_o}, 32'h0);
  endtask

  task automatic t_user_read;
    map(32'h0040_3ABC, 20'h00010, 4'h3, 20'h12345, 4'hF);
    walk(32'h0040_3ABC, 1'b0, 1'b1, 1'b0);
    chk(fetch_addr[0] == l1_addr(32'h0040_3ABC), "R1 first read", fetch_addr[0], l1_addr(32'h0040_3ABC));
    chk(fetch_addr[1] == 32'h0001_000C, "R2 second read", fetch_addr[1], 32'h0001_000C);
    expect_ok("R3 user read", 32'h1234_5ABC);
  endtask

  task automatic t_kernel_write_top;
    map(32'hFFC0_1004, 20'h00020, 4'h3, 20'hABCDE, 4'h7);
    walk(32'hFFC0_1004, 1'b1, 1'b0, 1'b0);
    chk(fetch_addr[0] == ROOT + 32'hFFC, "R1 max index", fetch_addr[0], ROOT + 32'hFFC);
    expect_ok("R6 kernel ignores user bit", 32'hABCD_E004);
  endtask

  task automatic t_invalid;
    walk(32'h0800_0123, 1'b0, 1'b0, 1'b0);
    expect_fault("R4 invalid dir", 3'd1, 1);
    map(32'h0080_5000, 20'h00030, 4'h3, 20'h00001, 4'h0);
    walk(32'h0080_5000, 1'b0, 1'b0, 1'b0);
    expect_fault("R4 invalid leaf", 3'd1, 2);
  endtask

  task automatic t_not_resident;
    map(32'h00C0_0000, 20'h00040, 4'h1, 20'h00002, 4'hF);
    walk(32'h00C0_0000, 1'b0, 1'b0, 1'b0);
    expect_fault("R5 dir not resident", 3'd2, 1);
    map(32'h0100_2000, 20'h00050, 4'h3, 20'h00003, 4'h1);
    walk(32'h0100_2000, 1'b0, 1'b0, 1'b0);
    expect_fault("R5 leaf not resident", 3'd2, 2);
  endtask

  task automatic t_perm;
    map(32'h0140_1000, 20'h00060, 4'h3, 20'h00004, 4'h7);
    walk(32'h0140_1000, 1'b0, 1'b1, 1'b0);
    expect_fault("R6 user violation", 3'd4, 2);
    map(32'h0180_1000, 20'h00070, 4'h3, 20'h00005, 4'h3);
    walk(32'h0180_1010, 1'b1, 1'b0, 1'b0);
    expect_fault("R7 write violation", 3'd3, 2);
    map(32'h01C0_1000, 20'h00080, 4'h1 | 4'h2, 20'h00006, 4'hB);
    walk(32'h01C0_1FFF, 1'b0, 1'b1, 1'b0);
    expect_ok("R7 read of read-only", 32'h0000_6FFF);
    map(32'h0200_1000, 20'h00090, 4'h7, 20'h00007, 4'hF);
    mem[l1_addr(32'h0200_1000)] = {20'h00090, 8'h0, 4'h3};
    walk(32'h0200_1000, 1'b1, 1'b1, 1'b0);
    expect_ok("R7 dir perm bits ignored", 32'h0000_7000);
  endtask

  task automatic t_priority;
    map(32'h0240_1000, 20'h000A0, 4'h3, 20'h00008, 4'h3);
    walk(32'h0240_1000, 1'b1, 1'b1, 1'b0);
    expect_fault("R8 user over write", 3'd4, 2);
    map(32'h0280_1000, 20'h000B0, 4'h3, 20'h00009, 4'h5);
    walk(32'h0280_1000, 1'b1, 1'b1, 1'b0);
    expect_fault("R8 not-resident over user", 3'd2, 2);
    map(32'h02C0_1000, 20'h000C0, 4'h3, 20'h0000A, 4'h2);
    walk(32'h02C0_1000, 1'b1, 1'b1, 1'b0);
    expect_fault("R8 invalid over all", 3'd1, 2);
  endtask

  task automatic t_busy_ignore;
    map(32'h0300_4321, 20'h000D0, 4'h3, 20'h0000B, 4'hF);
    walk(32'h0300_4321, 1'b0, 1'b0, 1'b1);
    expect_ok("R9 request while busy ignored", 32'h0000_B321);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_user_read();
        t_kernel_write_top();
        t_invalid();
        t_not_resident();
        t_perm();
        t_priority();
        t_busy_ignore();
      end
      begin
        repeat (20000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule